// File: doc/BRIEF.md
# Power-Supply Protection Supervisor

This block sits between the comparators of a flyback power-supply controller and its gate driver. It decides from a set of already digitized fault flags whether the power switch may toggle. It owns the start-up sequence: switching begins once the supply has crossed its turn-on level and the input line is high enough. After each start it marks a soft-start window, measured in millisecond ticks. Each fault has its own persistence filter. Some filters count switching cycles. Others count millisecond ticks. Several of them look at their flag only while the gate is off.

Every fault recovers on its own. Once a fault trips, switching stays off, and the block reports which fault came first. It waits for the supply to sag below the turn-off level and then climb back above the turn-on level before it starts again. The analog comparators, the threshold references and the PWM timing are outside this block. They supply the `cycle_tick` and `ms_tick` strobes and the flags.

Top module: `psu_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sw_en`, `soft_start` and `fault_code` are all zero.
- R2: From idle, `sw_en` goes high on the clock after `vcc_above_on` and `line_brownin` are both high with `vcc_below_off` low. Without `line_brownin` it stays low.
- R3: While switching, `vcc_below_off` clears `sw_en` on the next clock and leaves `fault_code` unchanged.
- R4: `vcc_ovp` high on 8 consecutive `cycle_tick` pulses stops switching and sets `fault_code` = 1.
- R5: `fb_ovp` is counted only on `cycle_tick` pulses while `gate_off` is high. The count holds while `gate_off` is low. 8 counted pulses trip the fault with `fault_code` = 2.
- R6: `cs_hot` follows the same gate-off counting rule as R5. 8 counted pulses trip the fault with `fault_code` = 4.
- R7: `fb_uvp` high together with `gate_off` stops switching within two clocks and sets `fault_code` = 3. While `gate_off` is low, `fb_uvp` is ignored.
- R8: A persistence count returns to zero when its flag is low during its sampling window. Counting must then restart from zero.
- R9: `soft_start` is high from each start until 5 `ms_tick` pulses have occurred, and it is high only while `sw_en` is high.
- R10: `comp_high` is counted on `ms_tick` only after soft start has ended. 80 such ticks trip the overload fault with `fault_code` = 5.
- R11: `line_brownout` high for 60 consecutive `ms_tick` pulses trips the fault with `fault_code` = 6. A restart also requires `line_brownin`.
- R12: After a trip, switching stays off and `fault_code` holds until `vcc_below_off` is seen, followed by a fresh start. The code clears to 0 at that start.
- R13: When several faults complete on the same clock, the lowest code wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_tick | input | 1 | One-clock pulse per switching cycle |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| gate_off | input | 1 | High while the power switch is off |
| vcc_above_on | input | 1 | Supply above the turn-on threshold |
| vcc_below_off | input | 1 | Supply below the turn-off threshold |
| vcc_ovp | input | 1 | Supply overvoltage flag |
| fb_ovp | input | 1 | Auxiliary-sense overvoltage flag |
| fb_uvp | input | 1 | Auxiliary-sense undervoltage flag |
| cs_hot | input | 1 | Current-sense pin over-temperature flag |
| comp_high | input | 1 | Loop-compensation node above overload level |
| line_brownin | input | 1 | Line above the brown-in level |
| line_brownout | input | 1 | Line below the brown-out level |
| sw_en | output | 1 | Switching allowed |
| soft_start | output | 1 | Soft-start window active |
| fault_code | output | 3 | First tripped fault, 0 when none |

## Verification
A start or a supply drop shows on `sw_en` one clock after the input is applied. A filter reaches its limit on the clock that carries the last qualifying strobe, and the state machine reacts on the clock after that. A fault therefore appears two clocks after its final strobe. The bench drives every strobe for one clock at a falling edge and then idles one more clock. It samples at the next falling edge, by which time both registers have updated. The near-miss checks use one pulse fewer than the limit and are sampled the same way, so a design that trips one pulse early is caught.

// File: rtl/psu_guard_pkg.sv
package psu_guard_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2
  } guard_state_t;

  localparam int unsigned NUM_TRIPS = 6;
  localparam int unsigned CODE_W    = 3;

  // trip index i reports code i+1
  localparam logic [CODE_W-1:0] FC_NONE      = 3'd0;
  localparam logic [CODE_W-1:0] FC_VCC_OVP   = 3'd1;
  localparam logic [CODE_W-1:0] FC_FB_OVP    = 3'd2;
  localparam logic [CODE_W-1:0] FC_FB_UVP    = 3'd3;
  localparam logic [CODE_W-1:0] FC_CS_HOT    = 3'd4;
  localparam logic [CODE_W-1:0] FC_OVERLOAD  = 3'd5;
  localparam logic [CODE_W-1:0] FC_BROWNOUT  = 3'd6;
endpackage

// File: rtl/pg_persist_filter.sv
module pg_persist_filter #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic step,
  input  logic window,
  input  logic flag,
  output logic trip
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (window && !flag) begin
      cnt <= '0;
    end else if (window && flag && step && cnt != LIM) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign trip = (cnt == LIM);

  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);

  assert_release_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (window && !flag) |=> (cnt == '0));
endmodule

// File: rtl/pg_softstart.sv
module pg_softstart #(
  parameter int unsigned SS_MS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ms_tick,
  output logic active
);
  localparam int unsigned CW = $clog2(SS_MS + 1);
  localparam logic [CW-1:0] LIM = CW'(SS_MS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (ms_tick && cnt != LIM) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign active = run && (cnt != LIM);

  assert_ss_bounded_R9: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);
endmodule

// File: rtl/pg_trip_arbiter.sv
module pg_trip_arbiter
  import psu_guard_pkg::*;
(
  input  logic [NUM_TRIPS-1:0] trips,
  output logic                 any_trip,
  output logic [CODE_W-1:0]    code
);
  always_comb begin
    code = FC_NONE;
    for (int i = NUM_TRIPS - 1; i >= 0; i--) begin
      if (trips[i]) code = CODE_W'(i + 1);
    end
  end

  assign any_trip = |trips;

  always_comb begin
    if (any_trip) assert_code_nonzero_R13: assert (code != FC_NONE);
  end
endmodule

// File: rtl/psu_guard.sv
module psu_guard
  import psu_guard_pkg::*;
#(
  parameter int unsigned CYC_DEBOUNCE = 8,
  parameter int unsigned SS_MS        = 5,
  parameter int unsigned OLP_MS       = 80,
  parameter int unsigned BNO_MS       = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cycle_tick,
  input  logic       ms_tick,
  input  logic       gate_off,
  input  logic       vcc_above_on,
  input  logic       vcc_below_off,
  input  logic       vcc_ovp,
  input  logic       fb_ovp,
  input  logic       fb_uvp,
  input  logic       cs_hot,
  input  logic       comp_high,
  input  logic       line_brownin,
  input  logic       line_brownout,
  output logic       sw_en,
  output logic       soft_start,
  output logic [2:0] fault_code
);
  localparam int unsigned LIMS [NUM_TRIPS] =
    '{CYC_DEBOUNCE, CYC_DEBOUNCE, 1, CYC_DEBOUNCE, OLP_MS, BNO_MS};

  guard_state_t          state;
  logic [CODE_W-1:0]     code_q;
  logic                  running;
  logic                  ss_active;
  logic [NUM_TRIPS-1:0]  flag_v, win_v, step_v, trip_v;
  logic                  any_trip;
  logic [CODE_W-1:0]     arb_code;
  logic                  start_ok;

  assign running = (state == ST_RUN);

  pg_softstart #(.SS_MS(SS_MS)) u_ss (
    .clk(clk), .rst(rst), .run(running), .ms_tick(ms_tick), .active(ss_active)
  );

  // per-source flag, sampling window and counting strobe
  assign flag_v = {line_brownout, comp_high, cs_hot, fb_uvp, fb_ovp, vcc_ovp};
  assign win_v  = {1'b1, ~ss_active, gate_off, gate_off, gate_off, 1'b1};
  assign step_v = {ms_tick, ms_tick, cycle_tick, 1'b1, cycle_tick, cycle_tick};

  for (genvar g = 0; g < NUM_TRIPS; g++) begin : g_filt
    pg_persist_filter #(.LIMIT(LIMS[g])) u_filt (
      .clk(clk), .rst(rst), .en(running),
      .step(step_v[g]), .window(win_v[g]), .flag(flag_v[g]),
      .trip(trip_v[g])
    );
  end

  pg_trip_arbiter u_arb (.trips(trip_v), .any_trip(any_trip), .code(arb_code));

  assign start_ok = vcc_above_on && !vcc_below_off && line_brownin;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      code_q <= FC_NONE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_ok) begin
            state  <= ST_RUN;
            code_q <= FC_NONE;
          end
        end
        ST_RUN: begin
          if (vcc_below_off) begin
            state <= ST_IDLE;
          end else if (any_trip) begin
            state  <= ST_FAULT;
            code_q <= arb_code;
          end
        end
        ST_FAULT: begin
          if (vcc_below_off) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sw_en      = running;
  assign soft_start = ss_active;
  assign fault_code = code_q;

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en) |-> $past(vcc_above_on && line_brownin));

  assert_uvlo_stops_R3: assert property (@(posedge clk) disable iff (rst)
    (running && vcc_below_off) |=> (!sw_en && $stable(fault_code)));

  assert_ss_within_run_R9: assert property (@(posedge clk) disable iff (rst)
    soft_start |-> sw_en);

  assert_fault_holds_R12: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FAULT && !vcc_below_off) |=>
      (state == ST_FAULT && !sw_en && $stable(fault_code)));
endmodule

// File: tb/tb_psu_guard.sv
module tb_psu_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, cycle_tick, ms_tick, gate_off, vcc_above_on, vcc_below_off;
  logic vcc_ovp, fb_ovp, fb_uvp, cs_hot, comp_high, line_brownin, line_brownout;
  logic sw_en, soft_start;
  logic [2:0] fault_code;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psu_guard dut (
    .clk(clk), .rst(rst), .cycle_tick(cycle_tick), .ms_tick(ms_tick),
    .gate_off(gate_off), .vcc_above_on(vcc_above_on), .vcc_below_off(vcc_below_off),
    .vcc_ovp(vcc_ovp), .fb_ovp(fb_ovp), .fb_uvp(fb_uvp), .cs_hot(cs_hot),
    .comp_high(comp_high), .line_brownin(line_brownin), .line_brownout(line_brownout),
    .sw_en(sw_en), .soft_start(soft_start), .fault_code(fault_code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic cyc_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      cycle_tick = 1'b1; step();
      cycle_tick = 1'b0; step();
    end
  endtask

  task automatic ms_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1; step();
      ms_tick = 1'b0; step();
    end
  endtask

  task automatic restart();
    vcc_above_on = 1'b0; vcc_below_off = 1'b1; step(2);
    vcc_below_off = 1'b0; vcc_above_on = 1'b1; step();
    vcc_above_on = 1'b0; step();
  endtask

  task automatic t_reset();
    rst = 1'b1; cycle_tick = 0; ms_tick = 0; gate_off = 0; vcc_above_on = 0;
    vcc_below_off = 0; vcc_ovp = 0; fb_ovp = 0; fb_uvp = 0; cs_hot = 0;
    comp_high = 0; line_brownin = 0; line_brownout = 0;
    step(3);
    chk("R1 sw_en in reset", sw_en, 0);
    chk("R1 soft_start in reset", soft_start, 0);
    rst = 1'b0; step();
    chk("R1 fault_code after reset", fault_code, 0);
  endtask

  task automatic t_start_and_ss();
    vcc_above_on = 1'b1; step(2);
    chk("R2 no start without brown-in", sw_en, 0);
    line_brownin = 1'b1; step();
    chk("R2 start", sw_en, 1);
    chk("R9 soft start at start", soft_start, 1);
    vcc_above_on = 1'b0;
    ms_pulses(4);
    chk("R9 soft start after 4 ms", soft_start, 1);
    ms_pulses(1);
    chk("R9 soft start ends after 5 ms", soft_start, 0);
  endtask

  task automatic t_uvlo();
    vcc_below_off = 1'b1; step();
    chk("R3 supply drop stops", sw_en, 0);
    chk("R3 no code on drop", fault_code, 0);
    vcc_below_off = 1'b0; step();
  endtask

  task automatic t_vcc_ovp();
    restart();
    chk("R2 restart", sw_en, 1);
    vcc_ovp = 1'b1; cyc_pulses(7);
    vcc_ovp = 1'b0; step();
    vcc_ovp = 1'b1; cyc_pulses(7);
    chk("R8 count cleared by release", sw_en, 1);
    cyc_pulses(1);
    chk("R4 ovp trips", sw_en, 0);
    chk("R4 ovp code", fault_code, 1);
    vcc_ovp = 1'b0; vcc_above_on = 1'b1; step(3);
    chk("R12 no restart without drop", sw_en, 0);
    chk("R12 code held", fault_code, 1);
    vcc_above_on = 1'b0;
    restart();
    chk("R12 restart after drop", sw_en, 1);
    chk("R12 code cleared at restart", fault_code, 0);
  endtask

  task automatic t_fb_ovp();
    gate_off = 1'b0; fb_ovp = 1'b1; cyc_pulses(10);
    chk("R5 not counted with gate on", sw_en, 1);
    gate_off = 1'b1; cyc_pulses(7);
    chk("R5 seven gated cycles", sw_en, 1);
    cyc_pulses(1);
    chk("R5 fb ovp code", fault_code, 2);
    fb_ovp = 1'b0; gate_off = 1'b0;
    restart();
  endtask

  task automatic t_cs_hot();
    gate_off = 1'b0; cs_hot = 1'b1; cyc_pulses(9);
    chk("R6 not counted with gate on", sw_en, 1);
    gate_off = 1'b1; cyc_pulses(7);
    chk("R6 seven gated cycles", sw_en, 1);
    cyc_pulses(1);
    chk("R6 cs hot code", fault_code, 4);
    cs_hot = 1'b0; gate_off = 1'b0;
    restart();
  endtask

  task automatic t_fb_uvp();
    fb_uvp = 1'b1; step(4);
    chk("R7 ignored with gate on", sw_en, 1);
    gate_off = 1'b1; step(2);
    chk("R7 uvp trips", sw_en, 0);
    chk("R7 uvp code", fault_code, 3);
    fb_uvp = 1'b0; gate_off = 1'b0;
    restart();
  endtask

  task automatic t_overload();
    comp_high = 1'b1; ms_pulses(5);
    chk("R10 soft start over", soft_start, 0);
    ms_pulses(79);
    chk("R10 not before 80 ms", sw_en, 1);
    ms_pulses(1);
    chk("R10 overload code", fault_code, 5);
    comp_high = 1'b0;
    restart();
  endtask

  task automatic t_brownout();
    line_brownout = 1'b1; ms_pulses(59);
    chk("R11 not before 60 ms", sw_en, 1);
    ms_pulses(1);
    chk("R11 brownout code", fault_code, 6);
    line_brownout = 1'b0; line_brownin = 1'b0;
    restart();
    chk("R11 no restart without brown-in", sw_en, 0);
    line_brownin = 1'b1; vcc_above_on = 1'b1; step();
    vcc_above_on = 1'b0;
    chk("R11 restart with brown-in", sw_en, 1);
  endtask

  task automatic t_priority();
    gate_off = 1'b1; vcc_ovp = 1'b1; cs_hot = 1'b1; cyc_pulses(8);
    chk("R13 lowest code wins", fault_code, 1);
    gate_off = 1'b0; vcc_ovp = 1'b0; cs_hot = 1'b0;
    restart();
  endtask

  initial begin
    t_reset();
    t_start_and_ss();
    t_uvlo();
    t_vcc_ovp();
    t_fb_ovp();
    t_cs_hot();
    t_fb_uvp();
    t_overload();
    t_brownout();
    t_priority();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule